// File: doc/BRIEF.md
# Interrupt Source Event-State Buffer

This block keeps a two-bit event state for each of a small set of interrupt sources. Bit P records that a notification for the source has gone out and still waits for its end-of-interrupt (EOI). Bit Q records that another trigger came in while P was set. Triggers arrive as one-cycle hardware pulses, or as stores to a per-source trigger page. A coalescing state machine lets each source have at most one notification outstanding. Every notification that is accepted sets a bit in a pending vector. A round-robin arbiter drains that vector through a valid/ready port that carries the source index.

Software reaches the state through one memory-mapped request port. The address is made of a region bit (0 selects the state page, 1 selects the trigger page), the source index, and a 12-bit offset within the page. Special loads on the state page return the old state and can update it atomically in the same access. An EOI is done by a load at offset 0, or by a store at offset 0 when store-EOI support is built in. Read data returns one cycle after the request. A source set to state 01 is masked.

Top module: `pq_event_buffer`

## Requirements
- R1: After reset every source is in state 00, no notification is pending, `note_valid` is low and `mmio_rvalid` is low.
- R2: A load on the state page returns the state in `mmio_rdata` with P in bit 1 and Q in bit 0; all other data bits are zero. `mmio_rvalid` is high exactly in the cycle after each load request. A load at offset 0x800 leaves the state unchanged.
- R3: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 set the state to 00, 01, 10 and 11 respectively. Each returns the value held before the update.
- R4: Special loads (offsets 0x000, 0x800 and 0xC00–0xF00) take effect only when `mmio_size` is 3 (8 bytes). Any other size returns zero and leaves the state unchanged.
- R5: A trigger moves 00 to 10 and emits a notification. It moves 10 to 11, and it leaves 11 as 11 with no notification.
- R6: State 01 is masked: a trigger leaves it at 01 and emits no notification.
- R7: A load at offset 0 performs an EOI and returns the previous state. EOI moves 10 to 00, moves 11 to 10 and emits a new notification, and leaves 00 and 01 unchanged.
- R8: With store-EOI enabled, a store at offset 0 of the state page performs the same EOI. Stores at any other state-page offset have no effect.
- R9: A store at any offset of the trigger page triggers that source. A load from the trigger page returns zero and has no effect.
- R10: When an MMIO operation and a hardware trigger hit the same source in the same cycle, the MMIO operation is applied first. The trigger is then evaluated against the resulting state.
- R11: Pending notifications are handed out in round-robin order, starting after the last source granted. While `note_valid` is high and `note_ready` is low, `note_valid` and `note_src` hold steady.
- R12: Each notification sets that source's single pending bit, and a handshake clears it. A new notification that arrives in the same cycle as the handshake keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_trig | input | NUM_SRC | One-cycle trigger pulse per source |
| mmio_valid | input | 1 | MMIO request strobe |
| mmio_write | input | 1 | 1 = store, 0 = load |
| mmio_addr | input | 1+SRC_W+12 | {region, source, offset} |
| mmio_size | input | 2 | log2 of access size in bytes |
| mmio_rvalid | output | 1 | Read data valid, one cycle after a load |
| mmio_rdata | output | 64 | Load result; P in bit 1, Q in bit 0 |
| note_valid | output | 1 | A notification is offered |
| note_ready | input | 1 | Consumer accepts the notification |
| note_src | output | SRC_W | Source index of the offered notification |

## Verification
The hardest case to reach from the ports is a collision. It needs an MMIO update and a hardware trigger on the same source in the same cycle, while the drained source is re-notified during its own handshake. Random stimulus rarely lines these three up by chance. The bench uses directed steps to force a state and then, in one cycle, set it with a load while pulsing that source's trigger. The random phase keeps the MMIO traffic on a few sources and holds back `note_ready` at random. This makes same-source overlaps and long stalls with several pending sources common, and a bench model tracks every state and the round-robin pointer.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef logic [1:0] pq_t;

  localparam pq_t PQ_IDLE   = 2'b00;
  localparam pq_t PQ_MASKED = 2'b01;
  localparam pq_t PQ_PEND   = 2'b10;
  localparam pq_t PQ_AGAIN  = 2'b11;

  typedef enum logic [2:0] {OP_NONE, OP_GET, OP_SET, OP_EOI, OP_TRIG} op_e;

  typedef struct packed {
    logic notify;
    pq_t  next;
  } step_t;

  // Coalescing response to a trigger
  function automatic step_t on_trigger(pq_t s);
    step_t r;
    r.notify = 1'b0;
    r.next   = s;
    case (s)
      PQ_IDLE: begin r.next = PQ_PEND; r.notify = 1'b1; end
      PQ_PEND: r.next = PQ_AGAIN;
      default: r.next = s;
    endcase
    return r;
  endfunction

  // Response to an end-of-interrupt
  function automatic step_t on_eoi(pq_t s);
    step_t r;
    r.notify = 1'b0;
    r.next   = s;
    case (s)
      PQ_PEND:  r.next = PQ_IDLE;
      PQ_AGAIN: begin r.next = PQ_PEND; r.notify = 1'b1; end
      default:  r.next = s;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pq_mmio_decode.sv
module pq_mmio_decode
  import pq_pkg::*;
#(
  parameter int SRC_W        = 3,
  parameter int PAGE_W       = 12,
  parameter bit STORE_EOI_EN = 1'b1,
  localparam int ADDR_W      = 1 + SRC_W + PAGE_W
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output op_e               op,
  output logic [SRC_W-1:0]  src,
  output pq_t               set_val
);
  localparam logic [PAGE_W-1:0] OFF_EOI  = '0;
  localparam logic [PAGE_W-1:0] OFF_GET  = PAGE_W'('h800);
  localparam logic [PAGE_W-1:0] OFF_SET  = PAGE_W'('hC00);
  localparam logic [PAGE_W-1:0] SET_FLD  = PAGE_W'('h300);

  logic              trig_page;
  logic [PAGE_W-1:0] offset;
  logic              full_word;
  logic              store_eoi;

  assign trig_page = req_addr[ADDR_W-1];
  assign src       = req_addr[PAGE_W +: SRC_W];
  assign offset    = req_addr[PAGE_W-1:0];
  assign full_word = (req_size == 2'd3);
  assign set_val   = offset[9:8];

  generate
    if (STORE_EOI_EN) begin : g_st_eoi
      assign store_eoi = (offset == OFF_EOI);
    end else begin : g_no_st_eoi
      assign store_eoi = 1'b0;
    end
  endgenerate

  always_comb begin
    op = OP_NONE;
    if (req_valid) begin
      if (trig_page) begin
        if (req_write) op = OP_TRIG;
      end else if (req_write) begin
        if (store_eoi) op = OP_EOI;
      end else if (full_word) begin
        if (offset == OFF_EOI)                    op = OP_EOI;
        else if (offset == OFF_GET)               op = OP_GET;
        else if ((offset & ~SET_FLD) == OFF_SET)  op = OP_SET;
      end
    end
  end
endmodule

// File: rtl/pq_source_cell.sv
module pq_source_cell
  import pq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mmio_hit,
  input  op_e  op,
  input  pq_t  set_val,
  input  logic trig_in,
  output pq_t  state,
  output logic notify
);
  pq_t   after_mmio;
  pq_t   nxt;
  step_t eoi_r;
  step_t trg_r;
  logic  mmio_notify;

  always_comb begin
    after_mmio  = state;
    mmio_notify = 1'b0;
    eoi_r       = on_eoi(state);
    if (mmio_hit) begin
      case (op)
        OP_SET: after_mmio = set_val;
        OP_EOI: begin
          after_mmio  = eoi_r.next;
          mmio_notify = eoi_r.notify;
        end
        default: after_mmio = state;
      endcase
    end
    trg_r  = on_trigger(after_mmio);
    nxt    = trig_in ? trg_r.next : after_mmio;
    notify = mmio_notify | (trig_in & trg_r.notify);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PQ_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/pq_rr_arbiter.sv
module pq_rr_arbiter #(
  parameter int NUM_SRC = 8,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pending,
  input  logic               ready,
  output logic               valid,
  output logic [SRC_W-1:0]   src,
  output logic               take
);
  logic [SRC_W-1:0] ptr_q;
  logic             lock_q;
  logic [SRC_W-1:0] lock_src_q;
  logic             found;
  logic [SRC_W-1:0] pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM_SRC; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % NUM_SRC;
      if (!found && pending[idx]) begin
        found = 1'b1;
        pick  = SRC_W'(idx);
      end
    end
  end

  assign valid = lock_q | found;
  assign src   = lock_q ? lock_src_q : pick;
  assign take  = valid & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= SRC_W'(NUM_SRC - 1);
      lock_q     <= 1'b0;
      lock_src_q <= '0;
    end else begin
      if (take) ptr_q <= src;
      lock_q     <= valid & ~ready;
      lock_src_q <= src;
    end
  end
endmodule

// File: rtl/pq_event_buffer.sv
module pq_event_buffer
  import pq_pkg::*;
#(
  parameter int NUM_SRC      = 8,
  parameter bit STORE_EOI_EN = 1'b1,
  parameter int RDATA_W      = 64,
  localparam int SRC_W       = $clog2(NUM_SRC),
  localparam int PAGE_W      = 12,
  localparam int ADDR_W      = 1 + SRC_W + PAGE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hw_trig,
  input  logic               mmio_valid,
  input  logic               mmio_write,
  input  logic [ADDR_W-1:0]  mmio_addr,
  input  logic [1:0]         mmio_size,
  output logic               mmio_rvalid,
  output logic [RDATA_W-1:0] mmio_rdata,
  output logic               note_valid,
  input  logic               note_ready,
  output logic [SRC_W-1:0]   note_src
);
  op_e                  dec_op;
  logic [SRC_W-1:0]     dec_src;
  pq_t                  dec_set;
  pq_t                  pq_state [NUM_SRC];
  logic [2*NUM_SRC-1:0] pq_flat;
  logic [NUM_SRC-1:0]   hit_vec;
  logic [NUM_SRC-1:0]   notify_vec;
  logic [NUM_SRC-1:0]   pending_q;
  logic [NUM_SRC-1:0]   clr_vec;
  logic                 take;
  pq_t                  prev_sel;
  logic                 returns_state;

  pq_mmio_decode #(
    .SRC_W(SRC_W), .PAGE_W(PAGE_W), .STORE_EOI_EN(STORE_EOI_EN)
  ) u_dec (
    .req_valid(mmio_valid), .req_write(mmio_write), .req_addr(mmio_addr),
    .req_size(mmio_size), .op(dec_op), .src(dec_src), .set_val(dec_set)
  );

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign hit_vec[i] = (dec_op != OP_NONE) && (dec_src == SRC_W'(i));
      pq_source_cell u_cell (
        .clk(clk), .rst_n(rst_n), .mmio_hit(hit_vec[i]), .op(dec_op),
        .set_val(dec_set),
        .trig_in(hw_trig[i] | (hit_vec[i] && dec_op == OP_TRIG)),
        .state(pq_state[i]), .notify(notify_vec[i])
      );
      assign pq_flat[2*i +: 2] = pq_state[i];
      assign clr_vec[i] = take && (note_src == SRC_W'(i));
    end
  endgenerate

  // Handshake clears first, a fresh notification wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending_q <= '0;
    else        pending_q <= (pending_q & ~clr_vec) | notify_vec;
  end

  pq_rr_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .pending(pending_q), .ready(note_ready),
    .valid(note_valid), .src(note_src), .take(take)
  );

  assign prev_sel      = pq_state[dec_src];
  assign returns_state = !mmio_write &&
                         (dec_op == OP_GET || dec_op == OP_SET || dec_op == OP_EOI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mmio_rvalid <= 1'b0;
      mmio_rdata  <= '0;
    end else begin
      mmio_rvalid <= mmio_valid & ~mmio_write;
      mmio_rdata  <= returns_state ? RDATA_W'(prev_sel) : '0;
    end
  end
endmodule

module pq_event_buffer_chk #(
  parameter int NUM_SRC = 8,
  parameter int SRC_W   = 3,
  parameter int RDATA_W = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mmio_valid,
  input logic               mmio_write,
  input logic               mmio_rvalid,
  input logic [RDATA_W-1:0] mmio_rdata,
  input logic               note_valid,
  input logic               note_ready,
  input logic [SRC_W-1:0]   note_src,
  input logic [2*NUM_SRC-1:0] pq_flat,
  input logic [NUM_SRC-1:0] hit_vec,
  input logic [NUM_SRC-1:0] notify_vec,
  input logic [NUM_SRC-1:0] pending_q
);
  a_r2_rvalid_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mmio_valid && !mmio_write) |=> mmio_rvalid);
  a_r2_no_rvalid_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !(mmio_valid && !mmio_write) |=> !mmio_rvalid);
  a_r2_upper_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mmio_rvalid |-> (mmio_rdata[RDATA_W-1:2] == '0));
  a_r11_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (note_valid && !note_ready) |=> (note_valid && $stable(note_src)));
  a_r11_offer_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid |-> pending_q[note_src]);

  generate
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
      a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pq_flat[2*i +: 2] == 2'b01 && !hit_vec[i]) |-> !notify_vec[i]);
      a_r6_masked_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (pq_flat[2*i +: 2] == 2'b01 && !hit_vec[i]) |=> (pq_flat[2*i +: 2] == 2'b01));
      a_r12_notify_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        notify_vec[i] |=> pending_q[i]);
    end
  endgenerate
endmodule

bind pq_event_buffer pq_event_buffer_chk #(
  .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .RDATA_W(RDATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mmio_valid(mmio_valid), .mmio_write(mmio_write),
  .mmio_rvalid(mmio_rvalid), .mmio_rdata(mmio_rdata), .note_valid(note_valid),
  .note_ready(note_ready), .note_src(note_src), .pq_flat(pq_flat),
  .hit_vec(hit_vec), .notify_vec(notify_vec), .pending_q(pending_q)
);

// File: tb/pq_event_buffer_tb.sv
`timescale 1ns/1ps
module pq_event_buffer_tb;
  localparam int N      = 8;
  localparam int SW     = 3;
  localparam int AW     = 1 + SW + 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  hw_trig = '0;
  logic          mmio_valid = 1'b0;
  logic          mmio_write = 1'b0;
  logic [AW-1:0] mmio_addr = '0;
  logic [1:0]    mmio_size = 2'd3;
  logic          mmio_rvalid;
  logic [63:0]   mmio_rdata;
  logic          note_valid;
  logic          note_ready = 1'b0;
  logic [SW-1:0] note_src;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model
  logic [1:0] m_pq [N];
  bit         m_pend [N];
  int         m_ptr;
  bit         m_lock;
  int         m_lock_src;

  always #2.5 clk = ~clk;

  pq_event_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .hw_trig(hw_trig), .mmio_valid(mmio_valid),
    .mmio_write(mmio_write), .mmio_addr(mmio_addr), .mmio_size(mmio_size),
    .mmio_rvalid(mmio_rvalid), .mmio_rdata(mmio_rdata), .note_valid(note_valid),
    .note_ready(note_ready), .note_src(note_src)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // trigger table: 00->10 (notify), 10->11, 11->11, 01->01
  function automatic logic [2:0] m_trig(input logic [1:0] s);
    if (s == 2'b00) return 3'b110;
    if (s == 2'b10) return 3'b011;
    return {1'b0, s};
  endfunction

  // eoi table: 10->00, 11->10 (notify), else unchanged
  function automatic logic [2:0] m_eoi(input logic [1:0] s);
    if (s == 2'b10) return 3'b000;
    if (s == 2'b11) return 3'b110;
    return {1'b0, s};
  endfunction

  task automatic m_offer(output bit v, output int s);
    v = 1'b0; s = 0;
    if (m_lock) begin v = 1'b1; s = m_lock_src; return; end
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (m_ptr + k) % N;
      if (!v && m_pend[j]) begin v = 1'b1; s = j; end
    end
  endtask

  task automatic step(input logic [N-1:0] hw, input bit mv, input bit mw,
                      input bit treg, input int s, input int off,
                      input logic [1:0] sz, input bit rdy, input string tag);
    bit ev; int es; bit note [N]; bit trg [N]; logic [2:0] r;
    bit exp_rv; logic [1:0] exp_rd;
    hw_trig = hw; mmio_valid = mv; mmio_write = mw; mmio_size = sz;
    mmio_addr = {treg, SW'(s), 12'(off)}; note_ready = rdy;
    #0.5;
    m_offer(ev, es);
    check(tag, "note_valid", longint'(note_valid), longint'(ev));
    if (ev) check(tag, "note_src", longint'(note_src), longint'(es));
    @(posedge clk);
    foreach (note[i]) begin note[i] = 1'b0; trg[i] = hw[i]; end
    exp_rv = mv && !mw; exp_rd = 2'b00;
    if (mv) begin
      if (treg) begin
        if (mw) trg[s] = 1'b1;
      end else if (!mw) begin
        if (sz == 2'd3) begin
          if (off == 0) begin
            exp_rd = m_pq[s]; r = m_eoi(m_pq[s]); m_pq[s] = r[1:0]; note[s] = r[2];
          end else if (off == 'h800) begin
            exp_rd = m_pq[s];
          end else if (off == 'hC00 || off == 'hD00 || off == 'hE00 || off == 'hF00) begin
            exp_rd = m_pq[s]; m_pq[s] = 2'((off >> 8) & 3);
          end
        end
      end else if (off == 0) begin
        r = m_eoi(m_pq[s]); m_pq[s] = r[1:0]; note[s] = r[2];
      end
    end
    for (int i = 0; i < N; i++) begin
      if (trg[i]) begin
        r = m_trig(m_pq[i]); m_pq[i] = r[1:0]; note[i] = note[i] | r[2];
      end
    end
    if (ev && rdy) begin m_pend[es] = 1'b0; m_ptr = es; end
    for (int i = 0; i < N; i++) if (note[i]) m_pend[i] = 1'b1;
    m_lock = ev && !rdy; m_lock_src = es;
    @(negedge clk);
    check(tag, "mmio_rvalid", longint'(mmio_rvalid), longint'(exp_rv));
    if (exp_rv) check(tag, "mmio_rdata", longint'(mmio_rdata), longint'(exp_rd));
    hw_trig = '0; mmio_valid = 1'b0;
  endtask

  task automatic ld(input int s, input int off, input string tag);
    step('0, 1, 0, 0, s, off, 2'd3, 1, tag);
  endtask

  task automatic idle(input bit rdy, input string tag);
    step('0, 0, 0, 0, 0, 0, 2'd3, rdy, tag);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin m_pq[i] = 2'b00; m_pend[i] = 1'b0; end
    m_ptr = N - 1; m_lock = 1'b0; m_lock_src = 0;
    repeat (3) @(negedge clk);
    check("R1", "mmio_rvalid", longint'(mmio_rvalid), 0);
    check("R1", "note_valid", longint'(note_valid), 0);
    rst_n = 1'b1;
    idle(1, "R1");
    ld(3, 'h800, "R1");
    // R3 set loads return old value
    ld(1, 'hF00, "R3"); ld(1, 'h800, "R2");
    ld(1, 'hC00, "R3"); ld(1, 'hE00, "R3"); ld(1, 'hD00, "R3"); ld(1, 'h800, "R3");
    // R6 masked source ignores trigger
    step(8'h02, 0, 0, 0, 0, 0, 2'd3, 1, "R6"); idle(1, "R6"); ld(1, 'h800, "R6");
    // R4 wrong size has no effect
    step('0, 1, 0, 0, 1, 'hF00, 2'd2, 1, "R4"); ld(1, 'h800, "R4");
    step('0, 1, 0, 0, 1, 'h000, 2'd1, 1, "R4"); ld(1, 'h800, "R4");
    // R5 trigger coalescing under backpressure
    step(8'h10, 0, 0, 0, 0, 0, 2'd3, 0, "R5");
    step(8'h10, 0, 0, 0, 0, 0, 2'd3, 0, "R5");
    step(8'h10, 0, 0, 0, 0, 0, 2'd3, 0, "R5");
    ld(4, 'h800, "R5");
    // R11 several pending, stalled, then drained in order
    step(8'h8D, 0, 0, 0, 0, 0, 2'd3, 0, "R11");
    for (int k = 0; k < 4; k++) idle(0, "R11");
    for (int k = 0; k < 6; k++) idle(1, "R11");
    // R7 EOI by load
    ld(4, 'h000, "R7"); idle(1, "R7"); ld(4, 'h800, "R7");
    ld(4, 'h000, "R7"); ld(4, 'h800, "R7"); ld(1, 'h000, "R7"); ld(1, 'h800, "R7");
    // R8 EOI by store, other store offsets ignored
    ld(4, 'hF00, "R8");
    step('0, 1, 1, 0, 4, 'h800, 2'd3, 1, "R8"); ld(4, 'h800, "R8");
    step('0, 1, 1, 0, 4, 'h000, 2'd3, 1, "R8"); idle(1, "R8"); ld(4, 'h800, "R8");
    // R9 trigger page
    step('0, 1, 1, 1, 5, 'h123, 2'd3, 1, "R9"); idle(1, "R9");
    step('0, 1, 0, 1, 5, 'h800, 2'd3, 1, "R9"); ld(5, 'h800, "R9");
    // R10 same-cycle set and trigger
    ld(6, 'hE00, "R10");
    step(8'h40, 1, 0, 0, 6, 'hC00, 2'd3, 1, "R10"); idle(1, "R10"); ld(6, 'h800, "R10");
    step(8'h40, 1, 0, 0, 6, 'hD00, 2'd3, 1, "R10"); ld(6, 'h800, "R10");
    // R12 re-notify during own handshake
    ld(2, 'hF00, "R12");
    step('0, 1, 0, 0, 2, 'h000, 2'd3, 1, "R12"); ld(2, 'hF00, "R12");
    step('0, 1, 0, 0, 2, 'h000, 2'd3, 1, "R12");
    idle(1, "R12"); idle(1, "R12"); idle(1, "R12");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [N-1:0] hw; bit mv, mw, tr; int s, off, pick; logic [1:0] sz;
      hw = '0;
      for (int i = 0; i < N; i++) if ($urandom % 8 == 0) hw[i] = 1'b1;
      mv = ($urandom % 2) == 0; mw = ($urandom % 3) == 0; tr = ($urandom % 5) == 0;
      s = $urandom % 4; pick = $urandom % 8;
      case (pick)
        0: off = 'h000; 1: off = 'h800; 2: off = 'hC00; 3: off = 'hD00;
        4: off = 'hE00; 5: off = 'hF00; 6: off = 'h400; default: off = 'h000;
      endcase
      sz = ($urandom % 10 == 0) ? 2'(($urandom % 3)) : 2'd3;
      step(hw, mv, mw, tr, s, off, sz, ($urandom % 10) < 7, "R12");
    end
    for (int k = 0; k < 12; k++) idle(1, "R11");
    for (int i = 0; i < N; i++) ld(i, 'h800, "R2");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule